// File: doc/BRIEF.md
# Single-Cycle Address Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses for a processor with 4 KB pages. It keeps a table of 64 translations. The upper 20 bits of the virtual address (the page number) are compared against every stored tag at the same time. The lowest matching slot number then selects a physical frame from a separate table that is indexed by slot. The translation is combinational. The result for a request is therefore valid in the same cycle the request is presented, so the core does not need an extra pipeline stage for it.

Privileged software fills the table one slot per cycle. It names the slot by its index and supplies the virtual page, the address-space tag, the physical frame and four attribute bits: valid, global, writable-dirty and uncached. A tag matches when it is valid, its page equals the request page, and either its address-space tag equals the request's or its global bit is set. A failed lookup raises a miss flag. A store that hits a slot whose dirty bit is clear raises a modification fault. Both are only reported to the core.

The lookup side carries a request-valid qualifier but no ready signal. The block accepts a lookup every cycle and never applies back-pressure. Writes are likewise accepted in every cycle they are asserted.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until a slot is written with its valid bit set.
- R2: A slot matches a lookup when its valid bit is 1, its stored page equals `lk_vaddr[31:12]`, and either its stored address-space tag equals `lk_asid` or its global bit is 1.
- R3: On a hit, `lk_paddr` equals the selected slot's 20-bit frame in bits 31:12 followed by `lk_vaddr[11:0]`, in the same cycle as the request. On a miss, or when no request is presented, `lk_paddr` is zero.
- R4: With `lk_valid` high, exactly one of `lk_hit` and `lk_miss` is 1. With `lk_valid` low, `lk_hit`, `lk_miss`, `lk_mod_fault` and `lk_uncached` are all 0.
- R5: When several slots match, the slot with the lowest index supplies the translation and the attributes.
- R6: `lk_mod_fault` is 1 exactly when a valid request with `lk_store` = 1 hits a slot whose dirty bit is 0. Loads never fault.
- R7: A write to a slot affects lookups from the following cycle on. A lookup in the same cycle as the write sees the old contents.
- R8: On a hit, `lk_uncached` equals the uncached bit of the selected slot.
- R9: A write replaces every field of the named slot. Writing with `wr_valid` = 0 removes that slot from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_vpn | input | 20 | Virtual page tag to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_pfn | input | 20 | Physical frame to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_global | input | 1 | Global bit to store (ignore address-space tag) |
| wr_dirty | input | 1 | Dirty bit to store (stores allowed when 1) |
| wr_uncached | input | 1 | Uncached bit to store |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | A slot matched |
| lk_miss | output | 1 | No slot matched |
| lk_mod_fault | output | 1 | Store to a clean slot |
| lk_paddr | output | 32 | Translated physical address |
| lk_uncached | output | 1 | Selected slot is uncached |

## Verification
A corrupted tag, a stuck valid bit or a wrong priority decision shows up at the ports in the same cycle as the first lookup that touches the affected page. The symptom is a spurious hit, a spurious miss, or a frame that belongs to a higher slot. Frame or attribute corruption in the indexed table appears as a wrong upper address or fault bit, also in that cycle. The bench therefore compares every output against a behavioural table model on every clock. It uses overlapping and duplicated pages so that priority and invalidation errors cannot hide.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PFN_W     = 20;
  localparam int PA_W      = PFN_W + PAGE_BITS;
  localparam int ASID_W    = 8;

  typedef struct packed {
    logic              valid;
    logic              global_map;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
  } tag_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             dirty;
    logic             uncached;
  } frame_t;
endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  tag_t               wr_tag,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [ENTRIES-1:0] match
);
  tag_t slot_q [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g].valid <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_q[g] <= wr_tag;
      end
    end

    assign valid_vec[g] = slot_q[g].valid;
    assign match[g] = slot_q[g].valid
                    && (slot_q[g].vpn == lk_vpn)
                    && (slot_q[g].global_map || slot_q[g].asid == lk_asid);
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_vec == '0)); // R1
endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] grant;

  // Isolate the lowest set bit, used only for checking the encoder.
  assign grant = req & (~req + ENTRIES'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]); // R5
  AST_PICK_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]); // R5
endmodule

// File: rtl/xlat_frame_ram.sv
module xlat_frame_ram
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  frame_t           wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output frame_t           rd_data
);
  frame_t mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic              wr_dirty,
  input  logic              wr_uncached,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_mod_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_uncached
);
  tag_t               wr_tag;
  frame_t             wr_frame;
  frame_t             sel_frame;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit_now;

  assign wr_tag   = '{valid: wr_valid, global_map: wr_global, asid: wr_asid, vpn: wr_vpn};
  assign wr_frame = '{pfn: wr_pfn, dirty: wr_dirty, uncached: wr_uncached};

  xlat_tag_array #(.ENTRIES(ENTRIES)) tags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .lk_vpn (lk_vaddr[VA_W-1:PAGE_BITS]),
    .lk_asid(lk_asid),
    .match  (match_vec)
  );

  xlat_prio_pick #(.ENTRIES(ENTRIES)) pick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (match_vec),
    .any  (any_match),
    .idx  (hit_idx)
  );

  xlat_frame_ram #(.ENTRIES(ENTRIES)) frames_i (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_frame),
    .rd_idx (hit_idx),
    .rd_data(sel_frame)
  );

  assign hit_now      = lk_valid && any_match;
  assign lk_hit       = hit_now;
  assign lk_miss      = lk_valid && !any_match;
  assign lk_mod_fault = hit_now && lk_store && !sel_frame.dirty;
  assign lk_uncached  = hit_now && sel_frame.uncached;
  assign lk_paddr     = hit_now ? {sel_frame.pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_valid) && lk_valid
     && lk_vaddr[VA_W-1:PAGE_BITS] == $past(wr_vpn)
     && ($past(wr_global) || lk_asid == $past(wr_asid))) |-> lk_hit); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_mod_fault || lk_uncached)); // R4
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_paddr == '0 && !lk_mod_fault)); // R3
  AST_FAULT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mod_fault |-> (lk_store && lk_hit)); // R6
endmodule

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic [19:0] wr_pfn = '0;
  logic        wr_valid = 1'b0, wr_global = 1'b0, wr_dirty = 1'b0, wr_uncached = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        lk_hit, lk_miss, lk_mod_fault, lk_uncached;
  logic [31:0] lk_paddr;

  always #4 clk = ~clk;

  xlat_tlb dut_i (.*);

  // Behavioural table model
  bit         m_v [64];
  bit         m_g [64];
  bit         m_d [64];
  bit         m_nc[64];
  bit [7:0]   m_asid[64];
  bit [19:0]  m_vpn [64];
  bit [19:0]  m_pfn [64];

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic check_now();
    bit        e_hit = 0, e_miss = 0, e_flt = 0, e_nc = 0;
    bit [31:0] e_pa = '0;
    int        sel = -1;
    if (lk_valid) begin
      for (int i = 0; i < 64; i++) begin
        if (sel < 0 && m_v[i] && m_vpn[i] == lk_vaddr[31:12]
            && (m_g[i] || m_asid[i] == lk_asid)) sel = i;
      end
      if (sel >= 0) begin
        e_hit = 1;
        e_pa  = {m_pfn[sel], lk_vaddr[11:0]};
        e_flt = lk_store && !m_d[sel];
        e_nc  = m_nc[sel];
      end else begin
        e_miss = 1;
      end
    end
    n_run++;
    if (lk_hit !== e_hit || lk_miss !== e_miss || lk_mod_fault !== e_flt
        || lk_uncached !== e_nc || lk_paddr !== e_pa) begin
      n_fail++;
      $display("FAIL %s: got hit=%0b miss=%0b flt=%0b nc=%0b pa=%08h, expected hit=%0b miss=%0b flt=%0b nc=%0b pa=%08h",
               cur_req, lk_hit, lk_miss, lk_mod_fault, lk_uncached, lk_paddr,
               e_hit, e_miss, e_flt, e_nc, e_pa);
    end
  endtask

  // One clock: compare mid-cycle, then commit any write to the model at the edge.
  task automatic tick();
    #2;
    check_now();
    @(posedge clk);
    if (wr_en) begin
      m_v[wr_idx] = wr_valid;  m_g[wr_idx] = wr_global;
      m_d[wr_idx] = wr_dirty;  m_nc[wr_idx] = wr_uncached;
      m_asid[wr_idx] = wr_asid; m_vpn[wr_idx] = wr_vpn; m_pfn[wr_idx] = wr_pfn;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input int idx, input bit [19:0] vpn, input bit [7:0] asid,
                     input bit [19:0] pfn, input bit v, input bit g, input bit d, input bit nc);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
    wr_valid = v; wr_global = g; wr_dirty = d; wr_uncached = nc;
  endtask

  task automatic look(input bit [31:0] va, input bit [7:0] asid, input bit st);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";   // reset state: idle, then lookups all miss
    tick();
    look(32'h0000_0000, 8'd0, 1'b0); tick();
    look(32'h1234_5678, 8'd3, 1'b1); tick();

    cur_req = "R7";   // write slot 5; same-cycle lookup sees the old (empty) slot
    put(5, 20'h12345, 8'd3, 20'hABCDE, 1, 0, 1, 0);
    look(32'h1234_5678, 8'd3, 1'b0); tick();
    cur_req = "R3";   // next cycle: translated address, offset passed through
    look(32'h1234_5678, 8'd3, 1'b0); tick();
    look(32'h1234_5FFF, 8'd3, 1'b1); tick();

    cur_req = "R2";   // wrong address-space tag misses; global slot matches any tag
    look(32'h1234_5000, 8'd4, 1'b0); tick();
    put(7, 20'h00077, 8'd9, 20'h0FEED, 1, 1, 1, 0); tick();
    look(32'h0007_7123, 8'd200, 1'b0); tick();

    cur_req = "R5";   // duplicate page in slots 40 and 10: slot 10 wins
    put(40, 20'h55555, 8'd1, 20'h44444, 1, 0, 1, 1); tick();
    put(10, 20'h55555, 8'd1, 20'h11111, 1, 0, 0, 0); tick();
    look(32'h5555_5ABC, 8'd1, 1'b0); tick();

    cur_req = "R6";   // store to clean slot 10 faults, load does not
    look(32'h5555_5ABC, 8'd1, 1'b1); tick();
    look(32'h5555_5ABC, 8'd1, 1'b0); tick();

    cur_req = "R9";   // invalidate slot 10: slot 40 now supplies the frame
    put(10, 20'h55555, 8'd1, 20'h11111, 0, 0, 0, 0); tick();
    look(32'h5555_5001, 8'd1, 1'b1); tick();

    cur_req = "R8";   // slot 40 is uncached
    look(32'h5555_5002, 8'd1, 1'b0); tick();

    cur_req = "R4";   // no request: all flags low
    lk_valid = 1'b0; tick();

    cur_req = "R3";   // mixed traffic over a small page/tag set
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0)
        put($urandom_range(0, 63), 20'h00100 + 20'($urandom_range(0, 7)),
            8'($urandom_range(0, 3)), 20'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0),
            1'($urandom), 1'($urandom));
      lk_valid = ($urandom_range(0, 7) != 0);
      lk_vaddr = {20'h00100 + 20'($urandom_range(0, 7)), 12'($urandom)};
      lk_asid  = 8'($urandom_range(0, 3));
      lk_store = 1'($urandom);
      tick();
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule